// File: doc/BRIEF.md
# Filtered Edge Interrupt Detector

This block turns up to 24 synchronized input levels into interrupt requests for a parent interrupt controller. Each line has its own enable bit, a mode bit and a filter-enable bit. A single cycle count, shared by every line, sets how long an input must hold a new value before the filtered level follows it. The register bank that holds these control values, and the logic that synchronizes the pins, sit outside the block and drive its inputs directly.

In mode 0 a line presents its filtered level, and the parent decides polarity and level or edge sensing. In mode 1 the line reports both rising and falling transitions of its filtered level, one clock pulse per transition. This works only while the line's filter is on. The filter affects only the interrupt path. Any plain data read of the pins is taken ahead of this block and stays unfiltered.

Top module: `gpio_edge_irq_filter`

## Requirements
- R1: While a line's filter-enable bit is 0, its filtered level takes the value the pin had at the previous rising clock edge.
- R2: While a line's filter-enable bit is 1 and the shared count is N, the filtered level takes a new pin value at the (N+1)th consecutive rising edge that samples the pin differing from the filtered level. The count is 8 bits wide.
- R3: A differing pin value seen at fewer than N+1 consecutive edges never changes the filtered level. A sample equal to the filtered level restarts the count.
- R4: With mode bit 0, a line's interrupt output equals its enable bit ANDed with its filtered level.
- R5: With mode bit 1 and filter on, each change of the filtered level drives a one-clock high pulse on the interrupt output in the cycle in which the level changes. This holds for both rising and falling changes. At all other times the output is low.
- R6: With mode bit 1 and filter off, the interrupt output stays low whatever the pin does.
- R7: An enable bit of 0 holds that line's interrupt output low in the same cycle. A pulse that occurs while the line is masked is lost and does not appear when the line is unmasked.
- R8: A synchronous active-low reset loads every filtered level with the current pin value, even when the filter is on, and clears all counts and pulses.
- R9: Lines are independent. Each line uses only its own enable, mode and filter bits, and all lines share the one cycle count.
- R10: The count reaches its maximum of 255. With a count of 255, a change needs 256 consecutive differing samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_lvl | input | NLINES | Synchronized pin levels |
| line_en | input | NLINES | Per-line interrupt enable (1 = unmasked) |
| both_edge | input | NLINES | Per-line mode (1 = pulse on both edges) |
| flt_en | input | NLINES | Per-line glitch filter enable |
| flt_cycles | input | CNT_W | Shared filter count N |
| irq_out | output | NLINES | Per-line interrupt request |

## Verification
The assertions assume that pin levels arrive already synchronized to clk, and that the control inputs change only between clock edges. They also assume reset is asserted at time zero, so that the first sampled edge is inside reset. The bench drives every input on the falling clock edge and holds reset low through the first rising edge. It changes the shared count only while the affected lines are idle or the filter is off.

// File: rtl/gpio_edge_irq_filter.sv
module gpio_edge_irq_filter #(
  parameter int NLINES = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_lvl,
  input  logic [NLINES-1:0] line_en,
  input  logic [NLINES-1:0] both_edge,
  input  logic [NLINES-1:0] flt_en,
  input  logic [CNT_W-1:0]  flt_cycles,
  output logic [NLINES-1:0] irq_out
);

  logic [NLINES-1:0] lvl_q;
  logic [NLINES-1:0] pulse_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic             lv;
    logic             pl;
    logic [CNT_W-1:0] run;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lv  <= pin_lvl[g];
        run <= '0;
        pl  <= 1'b0;
      end else if (!flt_en[g]) begin
        lv  <= pin_lvl[g];
        run <= '0;
        pl  <= 1'b0;
      end else if (pin_lvl[g] == lv) begin
        run <= '0;
        pl  <= 1'b0;
      end else if (run >= flt_cycles) begin
        lv  <= pin_lvl[g];
        run <= '0;
        pl  <= 1'b1;
      end else begin
        run <= run + 1'b1;
        pl  <= 1'b0;
      end
    end

    assign lvl_q[g]   = lv;
    assign pulse_q[g] = pl;

    // R1
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_en[g] |=> lv == $past(pin_lvl[g]));

    // R2
    accept_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_en[g] && pin_lvl[g] != lv && run < flt_cycles) |=> $stable(lv));

    // R5
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pl |-> lv != $past(lv));

    // R8
    reset_load_chk: assert property (@(posedge clk)
      !rst_n |=> lv == $past(pin_lvl[g]));
  end

  assign irq_out = line_en & ((both_edge & flt_en & pulse_q) | (~both_edge & lvl_q));

endmodule

// File: tb/tb_gpio_edge_irq_filter.sv
module tb_gpio_edge_irq_filter;
  localparam int NL = 24;
  localparam int CW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] pin_lvl = '0;
  logic [NL-1:0] line_en = '0;
  logic [NL-1:0] both_edge = '0;
  logic [NL-1:0] flt_en = '0;
  logic [CW-1:0] flt_cycles = 8'd2;
  logic [NL-1:0] irq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  gpio_edge_irq_filter #(.NLINES(NL), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .line_en(line_en),
    .both_edge(both_edge), .flt_en(flt_en), .flt_cycles(flt_cycles),
    .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {pin, enable, mode, filter, expected irq}, count fixed at 2, same on all lines
  localparam logic [4:0] VEC [34] = '{
    5'b0_1_0_0_0, 5'b1_1_0_0_1, 5'b0_1_0_0_0,                          // R1 R4
    5'b0_1_0_1_0, 5'b1_1_0_1_0, 5'b1_1_0_1_0, 5'b1_1_0_1_1,            // R2
    5'b0_1_0_1_1, 5'b0_1_0_1_1, 5'b1_1_0_1_1,                          // R3 glitch
    5'b0_1_0_1_1, 5'b0_1_0_1_1, 5'b0_1_0_1_0,                          // R2 fall
    5'b0_1_1_1_0, 5'b1_1_1_1_0, 5'b1_1_1_1_0, 5'b1_1_1_1_1,            // R5 rise
    5'b1_1_1_1_0, 5'b0_1_1_1_0, 5'b0_1_1_1_0, 5'b0_1_1_1_1, 5'b0_1_1_1_0, // R5 fall
    5'b1_0_1_1_0, 5'b1_0_1_1_0, 5'b1_0_1_1_0, 5'b1_1_1_1_0,            // R7 lost pulse
    5'b1_0_0_1_0, 5'b1_1_0_1_1,                                        // R7 level mask
    5'b1_1_1_0_0, 5'b0_1_1_0_0, 5'b1_1_1_0_0, 5'b0_1_1_0_0,            // R6
    5'b0_1_0_0_0, 5'b1_1_0_0_1                                         // R1 R4
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NL-1:0] exp);
    checks++;
    if (irq_out !== exp) begin
      failures++;
      $display("FAIL %s: irq_out=%h expected=%h", req, irq_out, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected<=20000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: reset loads level even with filter on
    @(negedge clk);
    pin_lvl = 24'h5A5A5A; line_en = '1; flt_en = '1; both_edge = '0;
    step();
    check("R8 reset load", 24'h5A5A5A);
    rst_n = 1'b1;
    step();
    check("R8 after release", 24'h5A5A5A);

    for (int i = 0; i < 34; i++) begin
      pin_lvl   = {NL{VEC[i][4]}};
      line_en   = {NL{VEC[i][3]}};
      both_edge = {NL{VEC[i][2]}};
      flt_en    = {NL{VEC[i][1]}};
      step();
      check($sformatf("R1-table vec %0d", i), {NL{VEC[i][0]}});
    end

    // R9: lower 12 lines filtered, upper 12 bypassed
    pin_lvl = '0; line_en = '1; both_edge = '0; flt_en = 24'h000FFF;
    step();
    check("R9 independent lines t1", 24'h000FFF);
    step();
    check("R9 independent lines t2", 24'h000FFF);
    step();
    check("R9 independent lines t3", 24'h000000);

    // R10: maximum count needs 256 samples
    flt_en = '1; flt_cycles = 8'hFF; pin_lvl = '1;
    for (int k = 0; k < 255; k++) step();
    check("R10 before 256th sample", 24'h000000);
    step();
    check("R10 at 256th sample", 24'hFFFFFF);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule